// File: doc/BRIEF.md
# Debounced Quadrature Direction Detector

This block sits behind the two contact channels of a mechanical incremental rotary encoder. Each raw channel is brought into the system clock domain with a two-flop synchronizer. It then passes through a settling filter, which lets the filtered level follow a new input level only after that level has stayed unchanged for a programmable number of timing ticks. The filter treats rising and falling transitions the same way, so contact bounce on either edge is removed.

The filtered B channel is the timing reference. On each qualifying B transition the block works out the direction from the filtered A level and the new B level. It updates a direction level and fires a one-cycle step strobe in the same cycle. An edge-select input matches the step rate to the encoder's detent spacing. Encoders with two detents per pulse step on both B edges. Encoders with one detent per pulse step on a single, chosen B edge.

The timing tick comes from two cascaded dividers of the system clock. With the defaults and a 2.048 MHz clock, the dividers of 4 and 64 give an 8 kHz tick, and 16 ticks give a 2 ms settling time.

Top module: `quad_dir_decoder`

## Requirements
- R1: During reset and after it, step_o is 0 and dir_o is 0. When reset ends, the filtered channels take the current synchronized input levels, so no step is issued until a real transition on B has settled.
- R2: A new level on a raw channel reaches the filter only after it has stayed unchanged for SETTLE_TICKS consecutive ticks. Any return to the old level before then restarts the wait. A pulse shorter than (SETTLE_TICKS-1) tick periods has no effect.
- R3: The settling rule of R2 applies in the same way to rising and to falling transitions of each channel.
- R4: A tick occurs once every PRE_DIV*TICK_DIV system clocks and lasts one cycle. With the test parameters (PRE_DIV=2, TICK_DIV=4, SETTLE_TICKS=4), the step follows a raw B change by 24 to 40 cycles.
- R5: On a qualifying rising edge of filtered B, dir_o takes the filtered A level. On a qualifying falling edge, dir_o takes the inverse of filtered A. So dir_o is 1 when A leads B and 0 when B leads A.
- R6: edge_sel_i selects which B edges qualify: 2'b00 and 2'b11 select both edges, 2'b01 selects rising edges only, and 2'b10 selects falling edges only.
- R7: step_o is high for exactly one clock per qualifying edge and in the same cycle as the updated dir_o. dir_o holds its value between steps.
- R8: A transition on channel A alone issues no step and leaves dir_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enc_a_i | input | 1 | Raw encoder channel A |
| enc_b_i | input | 1 | Raw encoder channel B (timing reference) |
| edge_sel_i | input | 2 | Qualifying B edges: 00/11 both, 01 rising, 10 falling |
| dir_o | output | 1 | Direction level, 1 when A leads B |
| step_o | output | 1 | One-cycle strobe per qualifying movement |

## Verification
The bench drives raw B glitches of both polarities shorter than the settling window. A filter that ignored one polarity, or that kept its count across a return to the old level, would let a false step through. It drives a burst of contact bounce that ends on a stable level and expects exactly one step; a filter that did not restart its count would step early or twice. It runs full clockwise and counterclockwise cycles under every edge-select code. Sampling A directly on a falling B edge, or swapping the rising and falling selections, would give the wrong direction or the wrong step count. It also holds still after reset at a non-zero input level and toggles A alone, where a block that primed its filters from zero, or that reacted to A, would emit spurious steps.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    EDGE_BOTH     = 2'b00,
    EDGE_RISE     = 2'b01,
    EDGE_FALL     = 2'b10,
    EDGE_BOTH_ALT = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/qdec_tick_gen.sv
module qdec_tick_gen #(
  parameter int unsigned PRE_DIV  = 4,
  parameter int unsigned TICK_DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PreW  = (PRE_DIV  > 1) ? $clog2(PRE_DIV)  : 1;
  localparam int unsigned PostW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PreW-1:0]  pre_q;
  logic [PostW-1:0] post_q;
  logic             pre_wrap, post_wrap;
  logic             tick_q;

  assign pre_wrap  = (pre_q  == PreW'(PRE_DIV - 1));
  assign post_wrap = (post_q == PostW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      post_q <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= pre_wrap && post_wrap;
      if (pre_wrap) begin
        pre_q  <= '0;
        post_q <= post_wrap ? '0 : post_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;

  // R4: tick is a single-cycle pulse (period >= 2 assumed)
  a_r4_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/qdec_settle.sv
module qdec_settle #(
  parameter int unsigned SETTLE_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  input  logic raw_i,
  output logic filt_o,
  output logic chg_o
);
  localparam int unsigned CntW = $clog2(SETTLE_TICKS + 1);

  logic [CntW-1:0] cnt_q;
  logic            filt_q, chg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      chg_q <= 1'b0;
      if (load_i) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else if (raw_i == filt_q) begin
        cnt_q <= '0;              // bounce back restarts the wait
      end else if (tick_i) begin
        if (cnt_q == CntW'(SETTLE_TICKS - 1)) begin
          filt_q <= raw_i;
          cnt_q  <= '0;
          chg_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign filt_o = filt_q;
  assign chg_o  = chg_q;

  // R2: filtered level moves only on a tick, apart from the start-up load
  a_r2_move_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(filt_q) && !$past(load_i)) |-> $past(tick_i));
  // R3: change strobe marks every settled transition, rising or falling
  a_r3_chg_marks_move: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_q |-> !$stable(filt_q));
endmodule

// File: rtl/qdec_dir.sv
module qdec_dir
  import qdec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       a_filt_i,
  input  logic       b_filt_i,
  input  logic       b_chg_i,
  input  logic [1:0] edge_sel_i,
  output logic       dir_o,
  output logic       step_o
);
  logic b_rise, b_fall, qual;
  logic dir_q, step_q;

  assign b_rise = b_chg_i &&  b_filt_i;
  assign b_fall = b_chg_i && !b_filt_i;

  always_comb begin
    unique case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: qual = b_rise;
      EDGE_FALL: qual = b_fall;
      default:   qual = b_chg_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= 1'b0;
      step_q <= 1'b0;
    end else begin
      step_q <= qual;
      // A leads B when A already equals the new B level
      if (qual) dir_q <= (a_filt_i == b_filt_i);
    end
  end

  assign dir_o  = dir_q;
  assign step_o = step_q;

  // R7: strobe lasts one cycle
  a_r7_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |=> !step_q);
  // R7: direction holds between steps
  a_r7_dir_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_q |-> $stable(dir_q));
  // R8: every step follows a settled B change
  a_r8_step_from_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> $past(b_chg_i));
  // R6: rising-only selection steps with B high
  a_r6_rise_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q && $past(edge_sel_i) == EDGE_RISE) |-> b_filt_i);
endmodule

// File: rtl/quad_dir_decoder.sv
module quad_dir_decoder #(
  parameter int unsigned PRE_DIV      = 4,
  parameter int unsigned TICK_DIV     = 64,
  parameter int unsigned SETTLE_TICKS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enc_a_i,
  input  logic       enc_b_i,
  input  logic [1:0] edge_sel_i,
  output logic       dir_o,
  output logic       step_o
);
  localparam int unsigned NumCh  = 2;
  localparam int unsigned ChA    = 0;
  localparam int unsigned ChB    = 1;
  localparam int unsigned SyncLat = 2;

  logic [NumCh-1:0] raw_sync, filt, chg;
  logic             tick;
  logic [1:0]       init_q;
  logic             init_done, load;

  qdec_sync #(.WIDTH(NumCh)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({enc_b_i, enc_a_i}),
    .q_o    (raw_sync)
  );

  qdec_tick_gen #(.PRE_DIV(PRE_DIV), .TICK_DIV(TICK_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  // prime the filters once the synchronizer holds real input levels
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        init_q <= '0;
    else if (!init_done) init_q <= init_q + 1'b1;
  end
  assign init_done = (init_q > 2'(SyncLat));
  assign load      = (init_q == 2'(SyncLat));

  for (genvar ch = 0; ch < NumCh; ch++) begin : g_ch
    qdec_settle #(.SETTLE_TICKS(SETTLE_TICKS)) i_settle (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .tick_i (tick && init_done),
      .raw_i  (raw_sync[ch]),
      .filt_o (filt[ch]),
      .chg_o  (chg[ch])
    );
  end

  qdec_dir i_dir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_filt_i   (filt[ChA]),
    .b_filt_i   (filt[ChB]),
    .b_chg_i    (chg[ChB]),
    .edge_sel_i (edge_sel_i),
    .dir_o      (dir_o),
    .step_o     (step_o)
  );

  // R1: no step before the filters are primed
  a_r1_quiet_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done |-> (!step_o && !dir_o));
endmodule

// File: tb/test_quad_dir_decoder.sv
module test_quad_dir_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b1;
  logic       enc_b = 1'b1;
  logic [1:0] edge_sel = 2'b00;
  logic       dir, step;

  int n_chk = 0, n_fail = 0;
  int step_cnt = 0, dbl_err = 0, dir_err = 0;
  int cyc = 0, last_step_cyc = 0;
  logic prev_step = 1'b0, prev_dir = 1'b0, last_dir = 1'b0;
  bit done = 1'b0;

  localparam int Hold = 60;

  always #10 clk = ~clk;   // 50 MHz

  quad_dir_decoder #(.PRE_DIV(2), .TICK_DIV(4), .SETTLE_TICKS(4)) i_quad_dir_decoder (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(enc_a), .enc_b_i(enc_b),
    .edge_sel_i(edge_sel), .dir_o(dir), .step_o(step)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (step) begin
        step_cnt++;
        last_dir      = dir;
        last_step_cyc = cyc;
      end
      if (step && prev_step) dbl_err++;
      if (!step && dir !== prev_dir) dir_err++;
    end
    prev_step = step;
    prev_dir  = dir;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic b, input int n);
    enc_a = a; enc_b = b;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    enc_a = 1'b1; enc_b = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 step in reset", int'(step), 0);
    check("R1 dir in reset", int'(dir), 0);
    rst_n = 1'b1;
    repeat (100) @(negedge clk);
    check("R1 no step from initial level", step_cnt, 0);
    check("R1 dir after reset", int'(dir), 0);
  endtask

  // start 11; clockwise 11->01->00->10->11
  task automatic t_cycle(input string tag, input logic cw, input logic [1:0] sel,
                         input int exp_steps, input int exp_dir);
    int s0;
    edge_sel = sel;
    s0 = step_cnt;
    if (cw) begin
      drive(0, 1, Hold); drive(0, 0, Hold); drive(1, 0, Hold); drive(1, 1, Hold);
    end else begin
      drive(1, 0, Hold); drive(0, 0, Hold); drive(0, 1, Hold); drive(1, 1, Hold);
    end
    check({tag, " step count"}, step_cnt - s0, exp_steps);
    check({tag, " direction"}, int'(last_dir), exp_dir);
  endtask

  task automatic t_latency;
    int c0;
    edge_sel = 2'b00;
    drive(0, 1, Hold);
    c0 = cyc;
    drive(0, 0, Hold);
    check("R4 latency low bound", int'((last_step_cyc - c0) >= 24), 1);
    check("R4 latency high bound", int'((last_step_cyc - c0) <= 40), 1);
    drive(1, 0, Hold); drive(1, 1, Hold);
  endtask

  task automatic t_glitch;
    int s0;
    edge_sel = 2'b00;
    s0 = step_cnt;
    drive(1, 0, 16); drive(1, 1, Hold);   // low glitch on B
    check("R3 falling glitch ignored", step_cnt - s0, 0);
    drive(0, 1, Hold); drive(0, 0, Hold); // settle B low (one step)
    s0 = step_cnt;
    drive(0, 1, 16); drive(0, 0, Hold);   // high glitch on B
    check("R2 rising glitch ignored", step_cnt - s0, 0);
    drive(1, 0, Hold); drive(1, 1, Hold);
  endtask

  task automatic t_bounce;
    int s0;
    edge_sel = 2'b00;
    drive(0, 1, Hold);
    s0 = step_cnt;
    for (int i = 0; i < 6; i++) begin
      drive(0, 0, 5); drive(0, 1, 5);
    end
    drive(0, 0, Hold);
    check("R2 bounce gives one step", step_cnt - s0, 1);
    check("R5 bounce direction", int'(last_dir), 1);
    drive(1, 0, Hold); drive(1, 1, Hold);
  endtask

  task automatic t_a_only;
    int s0;
    logic d0;
    s0 = step_cnt;
    d0 = dir;
    drive(0, 1, Hold); drive(1, 1, Hold); drive(0, 1, Hold); drive(1, 1, Hold);
    check("R8 A alone no step", step_cnt - s0, 0);
    check("R8 A alone dir held", int'(dir), int'(d0));
  endtask

  initial begin
    t_reset();
    t_cycle("R5 R6 cw both", 1'b1, 2'b00, 2, 1);
    t_cycle("R5 R6 ccw both", 1'b0, 2'b00, 2, 0);
    t_cycle("R6 cw rise only", 1'b1, 2'b01, 1, 1);
    t_cycle("R6 ccw rise only", 1'b0, 2'b01, 1, 0);
    t_cycle("R6 cw fall only", 1'b1, 2'b10, 1, 1);
    t_cycle("R6 ccw fall only", 1'b0, 2'b10, 1, 0);
    t_cycle("R6 cw both alt", 1'b1, 2'b11, 2, 1);
    t_a_only();
    t_latency();
    t_glitch();
    t_bounce();
    check("R7 step one cycle wide", dbl_err, 0);
    check("R7 dir moves only with step", dir_err, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule